// File: doc/BRIEF.md
# K-Best Breadth-First Lattice Search Engine

This block runs the tree search at the heart of a MIMO lattice detector. It moves forward only and keeps a fixed number of paths. A search opens at the root with a single path of zero metric. Each accepted stage then grows every live survivor into all of its child branches. The child metric is the parent metric plus a branch metric supplied from outside. Across all children of the stage, only the K lowest accumulated metrics live on. After a fixed number of levels the search stops, and the path in survivor slot 0 is the hard decision.

The engine has no backtracking, so every symbol vector costs the same number of accepted stages. By default there are eight levels with four real amplitude choices each, so a symbol vector carries sixteen bits. Each stage weighs up to 4K = 20 contenders. Contenders that lose the selection are not kept. They appear on a side port during the stage that rejects them, with their metric and the stage index, so that a later soft-value unit can use them. The branch metrics are fed as one flat vector per stage. Contender c belongs to parent slot c / NB and carries label c mod NB.

Top module: `kbest_search`

## Requirements
- R1: After reset no survivor is valid and busy and done are low. One cycle after a start pulse exactly survivor slot 0 is valid, with metric 0 and an all-zero history, busy is high and stage reads 0.
- R2: Contender c (c = parent_slot*NB + label) exists only if its parent slot is valid. Its metric is the parent's accumulated metric plus the branch metric at bm[c*BW +: BW].
- R3: On each accepted stage the contenders with the K smallest metrics (or all of them, if fewer exist) become the new survivors. The survivors are held in slots 0 upward in ascending metric order, and slots left over are marked invalid.
- R4: Equal metrics are ordered by contender index, so the lower index wins the tie and takes the lower slot.
- R5: A survivor's history is its parent's history with the 2-bit label chosen at stage s written into bits [2s+1:2s].
- R6: While a stage is accepted, drop_valid[c] is high exactly for the valid contenders that are not kept. drop_metric[c*MW +: MW] gives their metric and drop_stage gives the stage index.
- R7: Accumulated metrics are unsigned MW-bit values that saturate at 2^MW-1 (1023 by default) and never wrap.
- R8: A stage is accepted only while busy and bm_valid is high with no start. The stage advances by one per accepted stage. After the LEVELS-th accepted stage, done pulses for one cycle and busy falls. best_metric and best_hist then show slot 0.
- R9: bm_valid while idle leaves the survivors unchanged and raises no drop strobe.
- R10: A start pulse during a search abandons it and reloads the root state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search from the root |
| bm_valid | input | 1 | Branch metrics for the current stage are present |
| bm | input | K*NB*BW (160) | Branch metric per contender, contender c at [c*BW +: BW] |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse after the last stage |
| stage | output | $clog2(LEVELS) (3) | Index of the stage to be accepted next |
| surv_valid | output | K (5) | Survivor slot holds a path |
| surv_metric | output | K*MW (50) | Survivor accumulated metrics, slot s at [s*MW +: MW] |
| surv_hist | output | K*2*LEVELS (80) | Survivor label histories, slot s at [s*16 +: 16] |
| best_metric | output | MW (10) | Metric of slot 0 |
| best_hist | output | 2*LEVELS (16) | History of slot 0, the hard decision |
| drop_valid | output | K*NB (20) | Contender was rejected in this stage |
| drop_metric | output | K*NB*MW (200) | Accumulated metric of every contender |
| drop_stage | output | $clog2(LEVELS) (3) | Stage index of the rejected contenders |

## Verification
A ranking fault first shows on the drop strobes, in the same cycle as the stage. A contender that is kept and also dropped, or a drop mask with a wrong count, can be seen before the clock edge. The cycle after that edge, the same fault shows as survivor slots out of order or a lost minimum. A history written at the wrong bit offset, or taken from the wrong parent, does not disturb any metric. It shows only in surv_hist and, at the end of the search, in best_hist, so every stage's histories are compared. Saturation and sequencing faults show as a wrapped small metric, or as done arriving a stage early or late.

// File: rtl/kbest_pkg.sv
package kbest_pkg;

  // Selection order: lower metric first, lower contender index breaks ties.
  function automatic bit ahead(input int unsigned ma, input int unsigned ia,
                               input int unsigned mb, input int unsigned ib);
    return (ma < mb) || ((ma == mb) && (ia < ib));
  endfunction

endpackage

// File: rtl/kbest_expand.sv
module kbest_expand #(
  parameter int K  = 5,
  parameter int NB = 4,
  parameter int MW = 10,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [K-1:0]      par_valid,
  input  logic [K*MW-1:0]   par_metric,
  input  logic [K*NB*BW-1:0] bm,
  output logic [K*NB-1:0]   c_valid,
  output logic [K*NB*MW-1:0] c_metric
);
  localparam int NC = K * NB;

  function automatic logic [MW-1:0] sat_add(input logic [MW-1:0] a, input logic [BW-1:0] b);
    logic [MW:0] s;
    s = {1'b0, a} + {{(MW + 1 - BW){1'b0}}, b};
    return s[MW] ? {MW{1'b1}} : s[MW-1:0];
  endfunction

  for (genvar i = 0; i < NC; i++) begin : g_child
    localparam int P = i / NB;
    assign c_valid[i]             = par_valid[P];
    assign c_metric[i*MW +: MW]   = sat_add(par_metric[P*MW +: MW], bm[i*BW +: BW]);

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_valid[i] |-> (c_metric[i*MW +: MW] >= par_metric[P*MW +: MW]));
  end

endmodule

// File: rtl/kbest_rank.sv
module kbest_rank #(
  parameter int NC = 20,
  parameter int K  = 5,
  parameter int MW = 10,
  parameter int RW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [NC-1:0]     c_valid,
  input  logic [NC*MW-1:0]  c_metric,
  output logic [NC-1:0]     keep,
  output logic [NC-1:0]     drop,
  output logic [NC*RW-1:0]  rank
);
  import kbest_pkg::*;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < NC; j++) begin
        if (j != i && c_valid[j] &&
            ahead(32'(c_metric[j*MW +: MW]), j, 32'(c_metric[i*MW +: MW]), i))
          cnt++;
      end
      rank[i*RW +: RW] = RW'(cnt);
      keep[i]          = c_valid[i] && (cnt < K);
      drop[i]          = en && c_valid[i] && !(cnt < K);
    end
  end

  // Boundary between kept and rejected sets, brought out for checking.
  logic [MW-1:0] worst_kept, best_drop;
  logic          any_drop;
  always_comb begin
    worst_kept = '0;
    best_drop  = '1;
    any_drop   = 1'b0;
    for (int i = 0; i < NC; i++) begin
      if (keep[i] && c_metric[i*MW +: MW] > worst_kept) worst_kept = c_metric[i*MW +: MW];
      if (drop[i]) begin
        any_drop = 1'b1;
        if (c_metric[i*MW +: MW] < best_drop) best_drop = c_metric[i*MW +: MW];
      end
    end
  end

  // R3
  keep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(keep) <= K));
  // R3
  keep_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && any_drop) |-> (worst_kept <= best_drop));
  // R6
  drop_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((keep & drop) == '0));

endmodule

// File: rtl/kbest_survivors.sv
module kbest_survivors #(
  parameter int K      = 5,
  parameter int NB     = 4,
  parameter int MW     = 10,
  parameter int LEVELS = 8,
  parameter int LW     = 2,
  parameter int SW     = 3,
  parameter int RW     = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    accept,
  input  logic [SW-1:0]           stage,
  input  logic [K*NB-1:0]         keep,
  input  logic [K*NB*RW-1:0]      rank,
  input  logic [K*NB*MW-1:0]      c_metric,
  output logic [K-1:0]            surv_valid,
  output logic [K*MW-1:0]         surv_metric,
  output logic [K*LW*LEVELS-1:0]  surv_hist
);
  localparam int NC = K * NB;
  localparam int HW = LW * LEVELS;

  logic [K-1:0]  v_q, v_n;
  logic [MW-1:0] m_q [K];
  logic [MW-1:0] m_n [K];
  logic [HW-1:0] h_q [K];
  logic [HW-1:0] h_n [K];

  always_comb begin
    for (int s = 0; s < K; s++) begin
      v_n[s] = 1'b0;
      m_n[s] = '0;
      h_n[s] = '0;
      for (int i = 0; i < NC; i++) begin
        if (keep[i] && rank[i*RW +: RW] == RW'(s)) begin
          v_n[s] = 1'b1;
          m_n[s] = c_metric[i*MW +: MW];
          h_n[s] = h_q[i / NB];
          h_n[s][int'(stage)*LW +: LW] = LW'(i % NB);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int s = 0; s < K; s++) begin
        m_q[s] <= '0;
        h_q[s] <= '0;
      end
    end else if (start) begin
      v_q <= K'(1);
      for (int s = 0; s < K; s++) begin
        m_q[s] <= '0;
        h_q[s] <= '0;
      end
    end else if (accept) begin
      v_q <= v_n;
      for (int s = 0; s < K; s++) begin
        m_q[s] <= m_n[s];
        h_q[s] <= h_n[s];
      end
    end
  end

  assign surv_valid = v_q;
  for (genvar s = 0; s < K; s++) begin : g_out
    assign surv_metric[s*MW +: MW] = m_q[s];
    assign surv_hist[s*HW +: HW]   = h_q[s];
  end

  for (genvar s = 0; s + 1 < K; s++) begin : g_order
    // R3
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[s+1] |-> (v_q[s] && (m_q[s] <= m_q[s+1])));
  end

  // R2
  best_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (m_q[0] >= $past(m_q[0])));

endmodule

// File: rtl/kbest_search.sv
module kbest_search #(
  parameter int K      = 5,
  parameter int NB     = 4,
  parameter int LEVELS = 8,
  parameter int MW     = 10,
  parameter int BW     = 8,
  localparam int LW    = $clog2(NB),
  localparam int NC    = K * NB,
  localparam int HW    = LW * LEVELS,
  localparam int SW    = $clog2(LEVELS),
  localparam int RW    = $clog2(NC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bm_valid,
  input  logic [NC*BW-1:0]  bm,
  output logic              busy,
  output logic              done,
  output logic [SW-1:0]     stage,
  output logic [K-1:0]      surv_valid,
  output logic [K*MW-1:0]   surv_metric,
  output logic [K*HW-1:0]   surv_hist,
  output logic [MW-1:0]     best_metric,
  output logic [HW-1:0]     best_hist,
  output logic [NC-1:0]     drop_valid,
  output logic [NC*MW-1:0]  drop_metric,
  output logic [SW-1:0]     drop_stage
);
  logic          busy_q, done_q;
  logic [SW-1:0] stage_q;
  logic          accept, last;

  assign accept = busy_q && bm_valid && !start;
  assign last   = (stage_q == SW'(LEVELS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stage_q <= '0;
    end else begin
      done_q <= accept && last;
      if (start) begin
        busy_q  <= 1'b1;
        stage_q <= '0;
      end else if (accept) begin
        if (last) begin
          busy_q  <= 1'b0;
          stage_q <= '0;
        end else begin
          stage_q <= stage_q + 1'b1;
        end
      end
    end
  end

  logic [NC-1:0]    c_valid, keep, drop;
  logic [NC*MW-1:0] c_metric;
  logic [NC*RW-1:0] rank;

  kbest_expand #(.K(K), .NB(NB), .MW(MW), .BW(BW)) u_expand (
    .clk(clk), .rst_n(rst_n),
    .par_valid(surv_valid), .par_metric(surv_metric), .bm(bm),
    .c_valid(c_valid), .c_metric(c_metric)
  );

  kbest_rank #(.NC(NC), .K(K), .MW(MW), .RW(RW)) u_rank (
    .clk(clk), .rst_n(rst_n), .en(accept),
    .c_valid(c_valid), .c_metric(c_metric),
    .keep(keep), .drop(drop), .rank(rank)
  );

  kbest_survivors #(.K(K), .NB(NB), .MW(MW), .LEVELS(LEVELS), .LW(LW), .SW(SW), .RW(RW)) u_surv (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .stage(stage_q),
    .keep(keep), .rank(rank), .c_metric(c_metric),
    .surv_valid(surv_valid), .surv_metric(surv_metric), .surv_hist(surv_hist)
  );

  assign busy        = busy_q;
  assign done        = done_q;
  assign stage       = stage_q;
  assign best_metric = surv_metric[MW-1:0];
  assign best_hist   = surv_hist[HW-1:0];
  assign drop_valid  = drop;
  assign drop_metric = c_metric;
  assign drop_stage  = stage_q;

  // R1
  root_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (surv_valid == K'(1) && best_metric == '0 && busy_q && stage_q == '0));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(accept)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> ($stable(surv_valid) && $stable(surv_metric) && $stable(surv_hist)));
  // R6
  idle_nodrop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (drop_valid == '0));

endmodule

// File: tb/test_kbest_search.sv
module test_kbest_search;
  localparam int K = 5, NB = 4, LEVELS = 8, MW = 10, BW = 8;
  localparam int LW = 2, NC = K * NB, HW = LW * LEVELS, SW = 3;
  localparam int MAXM = (1 << MW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bm_valid = 1'b0;
  logic [NC*BW-1:0] bm = '0;
  logic busy, done;
  logic [SW-1:0] stage, drop_stage;
  logic [K-1:0] surv_valid;
  logic [K*MW-1:0] surv_metric;
  logic [K*HW-1:0] surv_hist;
  logic [MW-1:0] best_metric;
  logic [HW-1:0] best_hist;
  logic [NC-1:0] drop_valid;
  logic [NC*MW-1:0] drop_metric;

  kbest_search i_kbest_search (
    .clk(clk), .rst_n(rst_n), .start(start), .bm_valid(bm_valid), .bm(bm),
    .busy(busy), .done(done), .stage(stage), .surv_valid(surv_valid),
    .surv_metric(surv_metric), .surv_hist(surv_hist), .best_metric(best_metric),
    .best_hist(best_hist), .drop_valid(drop_valid), .drop_metric(drop_metric),
    .drop_stage(drop_stage));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int unsigned seed = 32'h1234_5678;

  int ref_m[K];
  bit ref_v[K];
  logic [HW-1:0] ref_h[K];
  int ref_stage;
  int cur_bm[NC];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int rnd(input int modv);
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) % modv);
  endfunction

  task automatic chk_surv(input string req);
    for (int s = 0; s < K; s++) begin
      chk(req, $sformatf("slot %0d valid", s), surv_valid[s], ref_v[s]);
      if (ref_v[s]) begin
        chk(req, $sformatf("slot %0d metric", s), surv_metric[s*MW +: MW], ref_m[s]);
        chk(req, $sformatf("slot %0d history", s), surv_hist[s*HW +: HW], ref_h[s]);
      end
    end
  endtask

  task automatic start_search(input string req);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int s = 0; s < K; s++) begin
      ref_v[s] = (s == 0); ref_m[s] = 0; ref_h[s] = '0;
    end
    ref_stage = 0;
    chk_surv(req);
    chk(req, "busy after start", busy, 1);
    chk(req, "stage after start", stage, 0);
  endtask

  // One accepted stage: checks drops before the edge, survivors after it.
  task automatic apply_stage();
    int cm[NC];
    bit cv[NC];
    bit taken[NC];
    int nm[K];
    bit nv[K];
    logic [HW-1:0] nh[K];
    logic [NC-1:0] exp_drop;
    for (int i = 0; i < NC; i++) begin
      int sum;
      cv[i] = ref_v[i / NB];
      sum = ref_m[i / NB] + cur_bm[i];
      cm[i] = (sum > MAXM) ? MAXM : sum;
      taken[i] = 0;
    end
    for (int s = 0; s < K; s++) begin
      int b;
      b = -1;
      for (int i = 0; i < NC; i++)
        if (cv[i] && !taken[i] && (b < 0 || cm[i] < cm[b])) b = i;
      if (b >= 0) begin
        taken[b] = 1; nv[s] = 1; nm[s] = cm[b];
        nh[s] = ref_h[b / NB];
        nh[s][ref_stage*LW +: LW] = LW'(b % NB);
      end else begin
        nv[s] = 0; nm[s] = 0; nh[s] = '0;
      end
    end
    for (int i = 0; i < NC; i++) exp_drop[i] = cv[i] && !taken[i];

    @(negedge clk);
    bm_valid = 1'b1;
    for (int i = 0; i < NC; i++) bm[i*BW +: BW] = BW'(cur_bm[i]);
    #1;
    // R6: rejected contenders visible during the stage
    chk("R6", "drop mask", drop_valid, exp_drop);
    chk("R6", "drop stage", drop_stage, ref_stage);
    for (int i = 0; i < NC; i++)
      if (exp_drop[i]) chk("R2", $sformatf("dropped contender %0d metric", i),
                           drop_metric[i*MW +: MW], cm[i]);
    @(negedge clk);
    bm_valid = 1'b0;
    for (int s = 0; s < K; s++) begin
      ref_v[s] = nv[s]; ref_m[s] = nm[s]; ref_h[s] = nh[s];
    end
    chk_surv("R3");
    ref_stage++;
    chk("R8", "done pulse", done, ref_stage == LEVELS);
    chk("R8", "busy", busy, ref_stage != LEVELS);
    if (ref_stage != LEVELS) chk("R8", "stage advance", stage, ref_stage);
  endtask

  task automatic t_reset();
    chk("R1", "reset valid", surv_valid, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
  endtask

  // R2 R3 R5 R8: random branch metrics, optional idle gaps between stages
  task automatic t_random_run(input bit gaps);
    start_search("R1");
    for (int st = 0; st < LEVELS; st++) begin
      for (int i = 0; i < NC; i++) cur_bm[i] = rnd(64);
      apply_stage();
      if (gaps && st < LEVELS - 1) begin
        repeat (3) @(negedge clk);
        chk("R8", "stage holds in gap", stage, ref_stage);
        chk_surv("R8");
      end
    end
    @(negedge clk);
    chk("R8", "done falls", done, 0);
    chk("R8", "best metric", best_metric, ref_m[0]);
    chk("R5", "best history", best_hist, ref_h[0]);
  endtask

  // R4: all metrics equal, selection falls to contender index
  task automatic t_ties();
    start_search("R1");
    for (int st = 0; st < LEVELS; st++) begin
      for (int i = 0; i < NC; i++) cur_bm[i] = (st == 3) ? 7 : 0;
      apply_stage();
    end
    chk("R4", "tie slot 1 history", surv_hist[HW +: HW], ref_h[1]);
    chk("R4", "tie slot 4 history", surv_hist[4*HW +: HW], ref_h[4]);
  endtask

  // R7: large branch metrics saturate at the metric ceiling
  task automatic t_saturate();
    start_search("R1");
    for (int st = 0; st < LEVELS; st++) begin
      for (int i = 0; i < NC; i++) cur_bm[i] = 200 + (i % 3);
      apply_stage();
    end
    chk("R7", "saturated best", best_metric, MAXM);
  endtask

  // R9: strobes while idle are ignored
  task automatic t_idle();
    @(negedge clk);
    bm_valid = 1'b1;
    for (int i = 0; i < NC; i++) bm[i*BW +: BW] = BW'(rnd(256));
    #1;
    chk("R9", "idle drop mask", drop_valid, 0);
    @(negedge clk);
    @(negedge clk);
    bm_valid = 1'b0;
    chk_surv("R9");
    chk("R9", "idle busy", busy, 0);
  endtask

  // R10: restart in mid search
  task automatic t_restart();
    start_search("R1");
    for (int st = 0; st < 3; st++) begin
      for (int i = 0; i < NC; i++) cur_bm[i] = rnd(32);
      apply_stage();
    end
    start_search("R10");
    for (int st = 0; st < LEVELS; st++) begin
      for (int i = 0; i < NC; i++) cur_bm[i] = rnd(100);
      apply_stage();
    end
    chk("R10", "best after restart", best_hist, ref_h[0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random_run(1'b0);
    t_idle();
    t_random_run(1'b1);
    t_ties();
    t_saturate();
    t_restart();
    t_random_run(1'b0);
    report();
  end

endmodule